// File: doc/BRIEF.md
# Program Counter Sequencer

This block is the next-address unit of a small processor core. Every clock cycle it receives an operation that the decoder has already selected, a target address, an optional update of the condition code, and two register operands for equality testing. It then computes the program counter for the following cycle. The available behaviours are:

- plain sequential advance;
- an unconditional jump;
- four jumps that depend on the condition code;
- jump on operand equality;
- an increment-and-skip-if-zero loop counter;
- a call that saves its return address in a link register;
- a call and a return that use an internal return-address stack.

The return stack is run by a three-state controller: `SK_EMPTY`, `SK_PART` and `SK_FULL`. Its transitions are:

- `push_first`: from `SK_EMPTY` to `SK_PART`.
- `push_more`: stays in `SK_PART`.
- `push_last`: from `SK_PART` to `SK_FULL`.
- `push_over`: stays in `SK_FULL` and raises the error.
- `pop_full`: from `SK_FULL` to `SK_PART`.
- `pop_more`: stays in `SK_PART`.
- `pop_last`: from `SK_PART` to `SK_EMPTY`.
- `pop_under`: stays in `SK_EMPTY` and raises the error.

Instruction fetch, the ALU and memory-resident stack frames belong to neighbouring blocks and are not part of this one.

Top module: `pc_sequencer`

## Requirements
- R1: The 4-bit `op_sel` selects the operation. The encodings are: 0 sequential, 1 jump, 2 jump-if-positive, 3 jump-if-negative, 4 jump-if-zero, 5 jump-if-overflow, 6 jump-if-equal, 7 increment-and-skip, 8 link call, 9 stack call, 10 return, 11 counter load. For operation 0 and for codes 12 to 15, the PC advances by one instruction length (1), and no other output changes.
- R2: The condition code is stored in a 2-bit register. The code values are 0 zero, 1 positive, 2 negative and 3 overflow. The register loads `cc_in` at a clock edge only when `cc_wr` is 1. A conditional jump always tests the value stored before that edge.
- R3: Operation 1 loads `tgt_addr` into the PC.
- R4: Operations 2 to 5 load `tgt_addr` when the stored code equals positive, negative, zero and overflow respectively. When the code does not match, the PC advances by 1.
- R5: Operation 6 loads `tgt_addr` when `opnd_a` equals `opnd_b`. When they differ, the PC advances by 1.
- R6: Operation 7 adds 1 to the loop counter. When the new counter value is zero, the PC advances by 2. Otherwise the PC advances by 1.
- R7: Operation 11 loads the loop counter from `opnd_a`, and the PC advances by 1.
- R8: Operation 8 writes PC+1 into `link_reg` and loads `tgt_addr` into the PC.
- R9: Operation 9 pushes PC+1 onto an 8-entry stack and jumps to `tgt_addr`. Operation 10 pops the top entry into the PC. Nested calls return in last-in, first-out order.
- R10: A call when the stack holds 8 entries still jumps, but leaves the stack unchanged and sets `stk_err`. A return when the stack is empty advances the PC by 1 and sets `stk_err`. Once set, `stk_err` stays set until reset.
- R11: Reset clears the PC, the link register, the loop counter and `stk_err`. It also sets the condition code to zero and empties the stack.
- R12: All address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 4 | Decoded control operation |
| tgt_addr | input | 16 | Jump or call target |
| cc_wr | input | 1 | Load the condition code this cycle |
| cc_in | input | 2 | New condition code value |
| opnd_a | input | 16 | Compare operand A, also the counter load value |
| opnd_b | input | 16 | Compare operand B |
| pc | output | 16 | Current program counter |
| link_reg | output | 16 | Link register written by link calls |
| loop_cnt | output | 16 | Increment-and-skip counter |
| stk_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The assertions check the following on every cycle:

- sequential advance;
- jump targets;
- equality jumps;
- link-call writes;
- counter stepping;
- the stickiness of the error flag.

The condition code is internal, so the effect of `cc_wr` (including the old-value-versus-new-value race in the same cycle) can only be seen through the bench's jump scenarios. The same holds for last-in, first-out return ordering, the stack filling to its limit, and wrap-around. The bench covers these with a behavioural reference model.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [3:0] {
        OP_SEQ   = 4'd0,
        OP_JMP   = 4'd1,
        OP_BPOS  = 4'd2,
        OP_BNEG  = 4'd3,
        OP_BZER  = 4'd4,
        OP_BOVF  = 4'd5,
        OP_BEQ   = 4'd6,
        OP_ISZ   = 4'd7,
        OP_LCALL = 4'd8,
        OP_SCALL = 4'd9,
        OP_RET   = 4'd10,
        OP_CLD   = 4'd11
    } pcs_op_e;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_POS  = 2'd1,
        CC_NEG  = 2'd2,
        CC_OVF  = 2'd3
    } pcs_cc_e;

    typedef enum logic [1:0] {
        SK_EMPTY = 2'd0,
        SK_PART  = 2'd1,
        SK_FULL  = 2'd2
    } pcs_stk_e;
endpackage

// File: rtl/pcs_branch_eval.sv
module pcs_branch_eval
    import pcs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [3:0]    op_sel,
    input  pcs_cc_e       cc_now,
    input  logic [AW-1:0] opnd_a,
    input  logic [AW-1:0] opnd_b,
    output logic          is_xfer,
    output logic          take
);
    always_comb begin
        is_xfer = 1'b1;
        take    = 1'b0;
        unique case (op_sel)
            OP_JMP:  take = 1'b1;
            OP_BPOS: take = (cc_now == CC_POS);
            OP_BNEG: take = (cc_now == CC_NEG);
            OP_BZER: take = (cc_now == CC_ZERO);
            OP_BOVF: take = (cc_now == CC_OVF);
            OP_BEQ:  take = (opnd_a == opnd_b);
            default: is_xfer = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack
    import pcs_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_data,
    output logic [AW-1:0] top_data,
    output logic          empty,
    output logic          err
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    pcs_stk_e      state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          err_q, err_d;
    logic          wr_en;
    logic [AW-1:0] mem [DEPTH];
    logic [CW-1:0] top_idx;

    assign top_idx = cnt_q - CW'(1);

    // Transition logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        err_d   = err_q;
        wr_en   = 1'b0;
        unique case (state_q)
            SK_EMPTY: begin
                if (push) begin            // push_first
                    wr_en   = 1'b1;
                    cnt_d   = CW'(1);
                    state_d = (DEPTH == 1) ? SK_FULL : SK_PART;
                end else if (pop) begin    // pop_under
                    err_d = 1'b1;
                end
            end
            SK_PART: begin
                if (push) begin
                    wr_en = 1'b1;
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q == LAST) state_d = SK_FULL;   // push_last
                end else if (pop) begin
                    cnt_d = cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) state_d = SK_EMPTY; // pop_last
                end
            end
            SK_FULL: begin
                if (push) begin            // push_over
                    err_d = 1'b1;
                end else if (pop) begin    // pop_full
                    cnt_d   = cnt_q - CW'(1);
                    state_d = (DEPTH == 1) ? SK_EMPTY : SK_PART;
                end
            end
            default: state_d = SK_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SK_EMPTY;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            err_q   <= err_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[cnt_q[IW-1:0]] <= push_data;
    end

    // Outputs
    always_comb begin
        empty    = (state_q == SK_EMPTY);
        err      = err_q;
        top_data = mem[top_idx[IW-1:0]];
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcs_pkg::*;
#(
    parameter int AW        = 16,
    parameter int ILEN      = 1,
    parameter int STK_DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_sel,
    input  logic [AW-1:0] tgt_addr,
    input  logic          cc_wr,
    input  logic [1:0]    cc_in,
    input  logic [AW-1:0] opnd_a,
    input  logic [AW-1:0] opnd_b,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] link_reg,
    output logic [AW-1:0] loop_cnt,
    output logic          stk_err
);
    localparam logic [AW-1:0] STEP1 = AW'(ILEN);
    localparam logic [AW-1:0] STEP2 = AW'(2 * ILEN);

    logic [AW-1:0] pc_q, pc_d, link_q, link_d, cnt_q, cnt_d;
    logic [AW-1:0] seq_pc, skip_pc, cnt_inc, stk_top;
    pcs_cc_e       cc_q;
    logic          is_xfer, take, push, pop, stk_empty, err_w;

    pcs_branch_eval #(.AW(AW)) u_eval (
        .op_sel (op_sel),
        .cc_now (cc_q),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .is_xfer(is_xfer),
        .take   (take)
    );

    pcs_ret_stack #(.AW(AW), .DEPTH(STK_DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_data(seq_pc),
        .top_data (stk_top),
        .empty    (stk_empty),
        .err      (err_w)
    );

    always_comb begin
        seq_pc  = pc_q + STEP1;
        skip_pc = pc_q + STEP2;
        cnt_inc = cnt_q + AW'(1);
        pc_d    = seq_pc;
        link_d  = link_q;
        cnt_d   = cnt_q;
        push    = 1'b0;
        pop     = 1'b0;
        if (is_xfer) begin
            pc_d = take ? tgt_addr : seq_pc;
        end else begin
            unique case (op_sel)
                OP_ISZ: begin
                    cnt_d = cnt_inc;
                    pc_d  = (cnt_inc == '0) ? skip_pc : seq_pc;
                end
                OP_LCALL: begin
                    link_d = seq_pc;
                    pc_d   = tgt_addr;
                end
                OP_SCALL: begin
                    push = 1'b1;
                    pc_d = tgt_addr;
                end
                OP_RET: begin
                    pop  = 1'b1;
                    pc_d = stk_empty ? seq_pc : stk_top;
                end
                OP_CLD:  cnt_d = opnd_a;
                default: pc_d  = seq_pc;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            link_q <= '0;
            cnt_q  <= '0;
            cc_q   <= CC_ZERO;
        end else begin
            pc_q   <= pc_d;
            link_q <= link_d;
            cnt_q  <= cnt_d;
            if (cc_wr) cc_q <= pcs_cc_e'(cc_in);
        end
    end

    always_comb begin
        pc       = pc_q;
        link_reg = link_q;
        loop_cnt = cnt_q;
        stk_err  = err_w;
    end
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker
    import pcs_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_sel,
    input logic [AW-1:0] tgt_addr,
    input logic [AW-1:0] opnd_a,
    input logic [AW-1:0] opnd_b,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] link_reg,
    input logic [AW-1:0] loop_cnt,
    input logic          stk_err
);
    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SEQ) |=> (pc == $past(pc) + AW'(1))); // R1
    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_JMP) |=> (pc == $past(tgt_addr))); // R3
    AST_EQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_BEQ && opnd_a == opnd_b) |=> (pc == $past(tgt_addr))); // R5
    AST_EQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_BEQ && opnd_a != opnd_b) |=> (pc == $past(pc) + AW'(1))); // R5
    AST_ISZ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_ISZ) |=> (loop_cnt == $past(loop_cnt) + AW'(1))); // R6
    AST_LINK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_LCALL) |=> (link_reg == $past(pc) + AW'(1) && pc == $past(tgt_addr))); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err); // R10
    AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != OP_LCALL) |=> $stable(link_reg)); // R8
endmodule

bind pc_sequencer pcs_checker #(.AW(AW)) u_pcs_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .tgt_addr(tgt_addr),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .pc      (pc),
    .link_reg(link_reg),
    .loop_cnt(loop_cnt),
    .stk_err (stk_err)
);

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
    localparam logic [3:0] SEQ = 4'd0, JMP = 4'd1, BPOS = 4'd2, BNEG = 4'd3,
        BZER = 4'd4, BOVF = 4'd5, BEQ = 4'd6, ISZ = 4'd7, LCALL = 4'd8,
        SCALL = 4'd9, RET = 4'd10, CLD = 4'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [15:0] tgt_addr = '0, opnd_a = '0, opnd_b = '0;
    logic        cc_wr = 1'b0;
    logic [1:0]  cc_in = '0;
    logic [15:0] pc, link_reg, loop_cnt;
    logic        stk_err;

    int total = 0;
    int fails = 0;

    // reference model state
    logic [15:0] m_pc, m_link, m_cnt;
    logic [1:0]  m_cc;
    logic        m_err;
    logic [15:0] m_stk[$];

    always #5 clk = ~clk;

    pc_sequencer u_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .tgt_addr(tgt_addr),
        .cc_wr(cc_wr), .cc_in(cc_in), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .pc(pc), .link_reg(link_reg), .loop_cnt(loop_cnt), .stk_err(stk_err)
    );

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check(tag, "pc", pc, m_pc);
        check(tag, "link_reg", link_reg, m_link);
        check(tag, "loop_cnt", loop_cnt, m_cnt);
        check(tag, "stk_err", {15'd0, stk_err}, {15'd0, m_err});
    endtask

    task automatic model_reset();
        m_pc = 0; m_link = 0; m_cnt = 0; m_cc = 0; m_err = 0;
        m_stk.delete();
    endtask

    task automatic model_step(logic [3:0] op, logic [15:0] t, logic cw,
                              logic [1:0] cv, logic [15:0] a, logic [15:0] b);
        logic [15:0] nxt;
        nxt = m_pc + 16'd1;
        if (op == JMP) nxt = t;
        else if (op == BPOS && m_cc == 2'd1) nxt = t;
        else if (op == BNEG && m_cc == 2'd2) nxt = t;
        else if (op == BZER && m_cc == 2'd0) nxt = t;
        else if (op == BOVF && m_cc == 2'd3) nxt = t;
        else if (op == BEQ && a == b) nxt = t;
        else if (op == ISZ) begin
            m_cnt = m_cnt + 16'd1;
            if (m_cnt == 0) nxt = m_pc + 16'd2;
        end else if (op == LCALL) begin
            m_link = m_pc + 16'd1;
            nxt = t;
        end else if (op == SCALL) begin
            if (m_stk.size() == 8) m_err = 1'b1;
            else m_stk.push_back(m_pc + 16'd1);
            nxt = t;
        end else if (op == RET) begin
            if (m_stk.size() == 0) m_err = 1'b1;
            else nxt = m_stk.pop_back();
        end else if (op == CLD) m_cnt = a;
        if (cw) m_cc = cv;
        m_pc = nxt;
    endtask

    task automatic step(string tag, logic [3:0] op, logic [15:0] t = 16'h0,
                        logic cw = 1'b0, logic [1:0] cv = 2'd0,
                        logic [15:0] a = 16'h0, logic [15:0] b = 16'h1);
        op_sel = op; tgt_addr = t; cc_wr = cw; cc_in = cv; opnd_a = a; opnd_b = b;
        model_step(op, t, cw, cv, a, b);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op_sel = SEQ; cc_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        compare("R11");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset();
        // R1 sequential and unused encodings
        step("R1", SEQ);
        step("R1", SEQ);
        for (int k = 12; k < 16; k++) step("R1", 4'(k), 16'h4444, 1'b0, 2'd0, 16'h7, 16'h7);
        // R3 jump, R12 wrap
        step("R3", JMP, 16'h0200);
        step("R12", JMP, 16'hFFFF);
        step("R12", SEQ);
        // R2 / R4 condition code
        step("R4", BZER, 16'h0300);                    // reset code zero: taken
        step("R4", BPOS, 16'h0400);                    // not taken
        step("R2", BZER, 16'h0500, 1'b1, 2'd1);        // tests old zero, loads positive
        step("R4", BPOS, 16'h0600);                    // taken
        step("R2", BNEG, 16'h0700, 1'b0, 2'd2);        // no write: not taken
        step("R2", SEQ, 16'h0, 1'b1, 2'd2);
        step("R4", BNEG, 16'h0800);
        step("R4", BOVF, 16'h0900);
        step("R2", SEQ, 16'h0, 1'b1, 2'd3);
        step("R4", BOVF, 16'h0A00);
        step("R4", BZER, 16'h0B00);
        // R5 compare
        step("R5", BEQ, 16'h0C00, 1'b0, 2'd0, 16'h1234, 16'h1234);
        step("R5", BEQ, 16'h0D00, 1'b0, 2'd0, 16'h1234, 16'h1235);
        // R7 load, R6 loop
        step("R7", CLD, 16'h0, 1'b0, 2'd0, 16'hFFFD);
        step("R6", ISZ);
        step("R6", ISZ);
        step("R6", ISZ);
        step("R6", ISZ);
        // R8 link call
        step("R8", LCALL, 16'h2000);
        step("R8", SEQ);
        // R9 nesting
        step("R9", SCALL, 16'h3000);
        step("R9", SEQ);
        step("R9", SCALL, 16'h3100);
        step("R9", SCALL, 16'h3200);
        step("R9", RET);
        step("R9", RET);
        step("R9", SEQ);
        step("R9", RET);
        // R10 underflow then sticky
        step("R10", RET);
        step("R10", SEQ);
        do_reset();
        // R10 overflow
        for (int k = 0; k < 9; k++) step("R10", SCALL, 16'h5000 + 16'(k * 16));
        for (int k = 0; k < 8; k++) step("R10", RET);
        step("R10", RET);
        step("R10", JMP, 16'h0042);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule